// File: doc/BRIEF.md
# Driver Fault Latch and Two-Pin Flag Encoder

This block sits between the digital fault detectors of a stepper-motor power stage and the rest of the driver. It filters each fault indication, holds it once confirmed, turns the H-bridges off for the serious faults, and reports the most important one on a pair of open-drain flag pins. Each flag output is a pull-low enable: 1 means the pin is pulled low and 0 means it floats high.

The block also watches the raw 3-bit step-resolution code. A filtered copy of the code goes out for mode decoding. A separately filtered detector recognises the all-zero code as a standby request. Standby is the only way to clear a latched fault without a power-on reset. On leaving standby, a timed wake-up keeps the ready signal low, and the bridges disabled, before operation resumes.

Top module: `fault_flag_ctrl`

## Requirements
- R1: With no fault latched, both flag outputs are 0 (both pins released).
- R2: A latched fault sets the flags as follows. Over-temperature gives flagPullA=1 and flagPullB=1. Over-current gives flagPullA=1 and flagPullB=0. Open load gives flagPullA=0 and flagPullB=1.
- R3: When more than one fault is latched, the flags report the single highest-priority one. Over-temperature ranks above over-current, which ranks above open load.
- R4: A fault input is confirmed only after it has been sampled high on FAULT_FILT_CYC consecutive clock edges. The fault is latched on the following edge. A shorter pulse leaves the flags unchanged.
- R5: A latched fault stays latched after its input returns low.
- R6: bridgeOff is 1 while an over-temperature or over-current fault is latched. An open-load fault alone does not set bridgeOff.
- R7: While standby is 1, all latched faults are cleared from the next edge on, and fault inputs have no effect.
- R8: Asserting porN low clears all latched faults and returns every output to its reset state at once.
- R9: standby follows the condition resCodeRaw==3'b000, but changes only after the new condition has been sampled on STBY_FILT_CYC consecutive edges.
- R10: modeCode takes a new resCodeRaw value only after that same value has been sampled on MODE_FILT_CYC consecutive edges. Shorter excursions are ignored.
- R11: ready rises WAKE_CYC edges after the edge on which standby fell. ready is 0 whenever standby is 1, and bridgeOff is 1 whenever ready is 0.
- R12: During and after reset, before any edge: standby=1, ready=0, bridgeOff=1, both flags 0, modeCode=3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| overTemp | input | 1 | Over-temperature indication |
| overCurrent | input | 1 | Over-current indication |
| openLoad | input | 1 | Open-load indication |
| resCodeRaw | input | 3 | Unfiltered step-resolution code; 3'b000 requests standby |
| flagPullA | output | 1 | First flag pin pull-low enable |
| flagPullB | output | 1 | Second flag pin pull-low enable |
| bridgeOff | output | 1 | 1 forces all bridge transistors off |
| standby | output | 1 | Filtered standby state |
| ready | output | 1 | Wake-up delay has elapsed and operation is allowed |
| modeCode | output | 3 | Filtered step-resolution code |

## Verification
The bench builds the block with MODE_FILT_CYC=5, STBY_FILT_CYC=4, WAKE_CYC=10 and FAULT_FILT_CYC=3. At these values every filter window and the whole wake-up sequence take only a few clock cycles. This lets one short run hit both sides of each boundary: a pulse one edge short of a filter window against one that fills it, and the cycle just before ready against the cycle it rises. The short standby window also allows repeated clear-by-standby and power-on-reset sequences with faults held high.

// File: rtl/fault_flag_pkg.sv
package fault_flag_pkg;

  // Bit positions inside the packed fault vector (also the priority order).
  localparam int FLT_OL = 0;
  localparam int FLT_OC = 1;
  localparam int FLT_OT = 2;
  localparam int FLT_COUNT = 3;

  typedef struct packed {
    logic clearFaults;
    logic bridgeEnable;
  } ctrl_strobe_t;

  typedef enum logic [1:0] {
    PH_STBY = 2'd0,
    PH_WAKE = 2'd1,
    PH_RUN  = 2'd2
  } phase_e;

endpackage

// File: rtl/ff_glitch_filter.sv
// Passes a new input value to q only after it was sampled on N consecutive edges.
module ff_glitch_filter #(
  parameter int W = 1,
  parameter int N = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CW = $clog2(N + 1);

  logic [W-1:0]  cand;
  logic [CW-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      q      <= RST_VAL;
      cand   <= RST_VAL;
      runCnt <= '0;
    end else if (clr) begin
      q      <= RST_VAL;
      cand   <= RST_VAL;
      runCnt <= '0;
    end else if (d == q) begin
      runCnt <= '0;
    end else if (d != cand) begin
      cand   <= d;
      runCnt <= CW'(1);
    end else if (runCnt == CW'(N - 1)) begin
      q      <= d;
      runCnt <= '0;
    end else begin
      runCnt <= runCnt + CW'(1);
    end
  end

  // The output only ever moves to the value that was being sampled (R4, R9).
  assert_filter_follow_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(q) && !$past(clr)) |-> (q == $past(d)));

endmodule

// File: rtl/ff_fault_datapath.sv
module ff_fault_datapath
  import fault_flag_pkg::*;
#(
  parameter int MODE_FILT_CYC  = 63,
  parameter int STBY_FILT_CYC  = 47,
  parameter int FAULT_FILT_CYC = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrl_strobe_t         strobes,
  input  logic [FLT_COUNT-1:0] faultRaw,
  input  logic [2:0]           resCodeRaw,
  output logic                 flagPullA,
  output logic                 flagPullB,
  output logic                 stopFault,
  output logic                 standbyQ,
  output logic [2:0]           modeCode
);

  logic [FLT_COUNT-1:0] faultLvl;
  logic [FLT_COUNT-1:0] faultLat;
  logic                 stbyReq;

  // One confirmation filter and one sticky latch per fault source.
  for (genvar i = 0; i < FLT_COUNT; i++) begin : g_fault
    ff_glitch_filter #(.W(1), .N(FAULT_FILT_CYC), .RST_VAL(1'b0)) u_filt (
      .clk  (clk),
      .rstN (rstN),
      .clr  (strobes.clearFaults),
      .d    (faultRaw[i]),
      .q    (faultLvl[i])
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                    faultLat[i] <= 1'b0;
      else if (strobes.clearFaults) faultLat[i] <= 1'b0;
      else if (faultLvl[i])         faultLat[i] <= 1'b1;
    end

    // A latched fault survives until standby clears it (R5).
    assert_latch_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
      ($past(faultLat[i]) && !$past(strobes.clearFaults)) |-> faultLat[i]);
  end

  // Mode decoding and standby detection use their own filter windows.
  assign stbyReq = (resCodeRaw == 3'b000);

  ff_glitch_filter #(.W(1), .N(STBY_FILT_CYC), .RST_VAL(1'b1)) u_stbyFilt (
    .clk  (clk),
    .rstN (rstN),
    .clr  (1'b0),
    .d    (stbyReq),
    .q    (standbyQ)
  );

  ff_glitch_filter #(.W(3), .N(MODE_FILT_CYC), .RST_VAL(3'b000)) u_modeFilt (
    .clk  (clk),
    .rstN (rstN),
    .clr  (1'b0),
    .d    (resCodeRaw),
    .q    (modeCode)
  );

  // Priority encoder onto the two pull-low flag pins.
  always_comb begin
    if (faultLat[FLT_OT]) begin
      flagPullA = 1'b1; flagPullB = 1'b1;
    end else if (faultLat[FLT_OC]) begin
      flagPullA = 1'b1; flagPullB = 1'b0;
    end else if (faultLat[FLT_OL]) begin
      flagPullA = 1'b0; flagPullB = 1'b1;
    end else begin
      flagPullA = 1'b0; flagPullB = 1'b0;
    end
  end

  assign stopFault = faultLat[FLT_OT] | faultLat[FLT_OC];

endmodule

// File: rtl/ff_fault_ctrl.sv
module ff_fault_ctrl
  import fault_flag_pkg::*;
#(
  parameter int WAKE_CYC = 375
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         standbyQ,
  output ctrl_strobe_t strobes,
  output logic         ready
);
  localparam int WW = $clog2(WAKE_CYC + 1);

  phase_e        phase;
  logic [WW-1:0] wakeCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_STBY;
      wakeCnt <= '0;
    end else begin
      case (phase)
        PH_STBY: if (!standbyQ) begin
          phase   <= PH_WAKE;
          wakeCnt <= WW'(1);
        end
        PH_WAKE: if (standbyQ) begin
          phase   <= PH_STBY;
          wakeCnt <= '0;
        end else if (wakeCnt == WW'(WAKE_CYC - 1)) begin
          phase   <= PH_RUN;
        end else begin
          wakeCnt <= wakeCnt + WW'(1);
        end
        PH_RUN: if (standbyQ) begin
          phase   <= PH_STBY;
          wakeCnt <= '0;
        end
        default: begin
          phase   <= PH_STBY;
          wakeCnt <= '0;
        end
      endcase
    end
  end

  assign ready                = (phase == PH_RUN) && !standbyQ;
  assign strobes.clearFaults  = standbyQ;
  assign strobes.bridgeEnable = ready;

  // ready can only appear at the end of a wake-up interval.
  assert_wake_path_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> ($past(phase) == PH_WAKE));

endmodule

// File: rtl/fault_flag_ctrl.sv
module fault_flag_ctrl
  import fault_flag_pkg::*;
#(
  parameter int MODE_FILT_CYC  = 63,
  parameter int STBY_FILT_CYC  = 47,
  parameter int WAKE_CYC       = 375,
  parameter int FAULT_FILT_CYC = 8
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       overTemp,
  input  logic       overCurrent,
  input  logic       openLoad,
  input  logic [2:0] resCodeRaw,
  output logic       flagPullA,
  output logic       flagPullB,
  output logic       bridgeOff,
  output logic       standby,
  output logic       ready,
  output logic [2:0] modeCode
);

  ctrl_strobe_t         strobes;
  logic                 stopFault;
  logic                 standbyQ;
  logic [FLT_COUNT-1:0] faultRaw;

  always_comb begin
    faultRaw         = '0;
    faultRaw[FLT_OT] = overTemp;
    faultRaw[FLT_OC] = overCurrent;
    faultRaw[FLT_OL] = openLoad;
  end

  ff_fault_datapath #(
    .MODE_FILT_CYC  (MODE_FILT_CYC),
    .STBY_FILT_CYC  (STBY_FILT_CYC),
    .FAULT_FILT_CYC (FAULT_FILT_CYC)
  ) u_dp (
    .clk        (clk),
    .rstN       (porN),
    .strobes    (strobes),
    .faultRaw   (faultRaw),
    .resCodeRaw (resCodeRaw),
    .flagPullA  (flagPullA),
    .flagPullB  (flagPullB),
    .stopFault  (stopFault),
    .standbyQ   (standbyQ),
    .modeCode   (modeCode)
  );

  ff_fault_ctrl #(.WAKE_CYC(WAKE_CYC)) u_ctrl (
    .clk     (clk),
    .rstN    (porN),
    .standbyQ(standbyQ),
    .strobes (strobes),
    .ready   (ready)
  );

  assign standby   = standbyQ;
  assign bridgeOff = !strobes.bridgeEnable | stopFault;

  // Over-current and over-temperature codes both pull the first pin; the bridge must be off.
  assert_flag_stops_bridge_R6: assert property (@(posedge clk) disable iff (!porN)
    flagPullA |-> bridgeOff);

  // After a full cycle in standby, no fault can be reported.
  assert_standby_clears_R7: assert property (@(posedge clk) disable iff (!porN)
    (standby && $past(standby)) |-> (!flagPullA && !flagPullB));

endmodule

// File: tb/fault_flag_ctrl_tb_top.sv
module fault_flag_ctrl_tb_top;

  localparam int MF = 5;
  localparam int SF = 4;
  localparam int WK = 10;
  localparam int FF = 3;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic overTemp = 1'b0, overCurrent = 1'b0, openLoad = 1'b0;
  logic [2:0] resCodeRaw = 3'b111;
  logic flagPullA, flagPullB, bridgeOff, standby, ready;
  logic [2:0] modeCode;

  int nChecks = 0;
  int nFails  = 0;
  bit modelOn = 1'b0;

  always #10 clk = ~clk;

  fault_flag_ctrl #(
    .MODE_FILT_CYC(MF), .STBY_FILT_CYC(SF), .WAKE_CYC(WK), .FAULT_FILT_CYC(FF)
  ) dut_i (
    .clk(clk), .porN(porN), .overTemp(overTemp), .overCurrent(overCurrent),
    .openLoad(openLoad), .resCodeRaw(resCodeRaw), .flagPullA(flagPullA),
    .flagPullB(flagPullB), .bridgeOff(bridgeOff), .standby(standby),
    .ready(ready), .modeCode(modeCode)
  );

  // Behavioural reference: run lengths and sticky bits as integers.
  int mStby, mStbyRun, mMode, mCand, mModeRun, mWake;
  int mLvl[3], mRun[3], mLat[3];   // index 0 ot, 1 oc, 2 ol

  always @(posedge clk or negedge porN) begin
    if (!porN) begin
      mStby = 1; mStbyRun = 0; mMode = 0; mCand = 0; mModeRun = 0; mWake = 0;
      for (int i = 0; i < 3; i++) begin mLvl[i] = 0; mRun[i] = 0; mLat[i] = 0; end
    end else begin
      int fin[3];
      int cond;
      fin[0] = int'(overTemp); fin[1] = int'(overCurrent); fin[2] = int'(openLoad);
      for (int i = 0; i < 3; i++) begin
        if (mStby == 1) begin
          mLat[i] = 0; mLvl[i] = 0; mRun[i] = 0;
        end else begin
          if (mLvl[i] == 1) mLat[i] = 1;
          if (fin[i] == mLvl[i]) mRun[i] = 0;
          else begin
            mRun[i]++;
            if (mRun[i] == FF) begin mLvl[i] = fin[i]; mRun[i] = 0; end
          end
        end
      end
      if (mStby == 1) mWake = 0;
      else if (mWake < WK) mWake++;
      if (int'(resCodeRaw) == mMode) mModeRun = 0;
      else if (int'(resCodeRaw) != mCand) begin mCand = int'(resCodeRaw); mModeRun = 1; end
      else mModeRun++;
      if (mModeRun == MF) begin mMode = int'(resCodeRaw); mModeRun = 0; end
      cond = (resCodeRaw == 3'b000) ? 1 : 0;
      if (cond == mStby) mStbyRun = 0;
      else begin
        mStbyRun++;
        if (mStbyRun == SF) begin mStby = cond; mStbyRun = 0; end
      end
    end
  end

  function automatic int modelOut();
    int fa, fb, rdy, boff;
    fa = 0; fb = 0;
    if (mLat[0] == 1) begin fa = 1; fb = 1; end
    else if (mLat[1] == 1) begin fa = 1; fb = 0; end
    else if (mLat[2] == 1) begin fa = 0; fb = 1; end
    rdy  = (mStby == 0 && mWake == WK) ? 1 : 0;
    boff = (rdy == 0 || mLat[0] == 1 || mLat[1] == 1) ? 1 : 0;
    return (fa << 7) | (fb << 6) | (boff << 5) | (mStby << 4) | (rdy << 3) | mMode;
  endfunction

  function automatic int dutOut();
    return int'({flagPullA, flagPullB, bridgeOff, standby, ready, modeCode});
  endfunction

  // Cycle compare, sampled away from the rising edge.
  always @(negedge clk) begin
    if (modelOn) begin
      nChecks++;
      if (dutOut() != modelOut()) begin
        nFails++;
        $display("FAIL model compare (R1..R12) at %0t: actual %b expected %b",
                 $time, dutOut()[7:0], modelOut()[7:0]);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic flags(input string tag, input int exp);
    int act;
    act = int'({flagPullA, flagPullB});
    chk(act == exp, tag, act, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    cyc(3);
    modelOn = 1'b1;
    // R12 reset state
    chk(standby == 1'b1, "R12 standby", int'(standby), 1);
    chk(ready == 1'b0 && bridgeOff == 1'b1, "R12 ready/bridgeOff", int'({ready, bridgeOff}), 1);
    flags("R12 flags", 0);
    chk(modeCode == 3'b000, "R12 modeCode", int'(modeCode), 0);
    porN = 1'b1;

    // R9 / R11 leave standby, then count the wake-up
    while (standby) @(negedge clk);
    cyc(WK - 1);
    chk(ready == 1'b0 && bridgeOff == 1'b1, "R11 ready still low", int'(ready), 0);
    cyc(1);
    chk(ready == 1'b1 && bridgeOff == 1'b0, "R11 ready high", int'(ready), 1);
    chk(modeCode == 3'b111, "R10 modeCode follows", int'(modeCode), 7);
    flags("R1 no fault", 0);

    // R10 short excursion ignored, long one taken
    resCodeRaw = 3'b101; cyc(MF - 1); resCodeRaw = 3'b111; cyc(3);
    chk(modeCode == 3'b111, "R10 glitch ignored", int'(modeCode), 7);
    resCodeRaw = 3'b011; cyc(MF + 2);
    chk(modeCode == 3'b011, "R10 new code", int'(modeCode), 3);

    // R4 short fault pulse ignored, then open load latched
    openLoad = 1'b1; cyc(FF - 1); openLoad = 1'b0; cyc(4);
    flags("R4 short pulse", 0);
    openLoad = 1'b1; cyc(FF + 2);
    flags("R2 open load code", 1);
    chk(bridgeOff == 1'b0, "R6 open load keeps bridge", int'(bridgeOff), 0);
    openLoad = 1'b0; cyc(5);
    flags("R5 sticky", 1);

    // R3 priority ladder
    overCurrent = 1'b1; cyc(FF + 2);
    flags("R3 oc over ol", 2);
    chk(bridgeOff == 1'b1, "R6 oc stops bridge", int'(bridgeOff), 1);
    overTemp = 1'b1; cyc(FF + 2);
    flags("R3 ot over oc", 3);

    // R9 short standby request ignored
    resCodeRaw = 3'b000; cyc(SF - 1); resCodeRaw = 3'b011; cyc(3);
    chk(standby == 1'b0 && ready == 1'b1, "R9 short request", int'(standby), 0);
    flags("R9 faults kept", 3);

    // R7 standby clears, inputs ignored meanwhile
    resCodeRaw = 3'b000; cyc(SF + 4);
    chk(standby == 1'b1 && ready == 1'b0, "R7 in standby", int'(standby), 1);
    flags("R7 cleared with ot high", 0);
    overTemp = 1'b0; overCurrent = 1'b0;
    resCodeRaw = 3'b011; cyc(SF + WK + 4);
    chk(ready == 1'b1, "R11 ready again", int'(ready), 1);
    flags("R1 after wake", 0);
    overTemp = 1'b1; cyc(FF + 2);
    flags("R2 ot code", 3);
    overTemp = 1'b0;

    // R8 power-on reset clears
    @(negedge clk); #1 porN = 1'b0;
    cyc(1);
    flags("R8 por clears", 0);
    chk(standby == 1'b1, "R8 por standby", int'(standby), 1);
    cyc(2); porN = 1'b1;
    cyc(SF + WK + 4);
    chk(ready == 1'b1, "R11 ready after por", int'(ready), 1);
    overCurrent = 1'b1; cyc(FF + 2);
    flags("R2 oc code", 2);
    overCurrent = 1'b0; cyc(3);

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule